// File: doc/BRIEF.md
# USB Endpoint Stall Handshake Controller

This block sits beside the serial interface engine of a USB device. It holds one 8-bit control word that firmware reads and writes through a small register port. From that word it chooses the handshake for each token that reaches a covered endpoint. The covered endpoints are:

- endpoint 0 in both directions
- endpoint 1 OUT
- endpoints 2 and 3 IN

Stall flags force a STALL response. Two status-stage flags steer the reply in the status stage of a control transfer on endpoint 0. That reply stays NAK until firmware either acknowledges the stage or stalls it.

The engine reports three kinds of event: a setup token has arrived, a status-stage ACK has gone out, and a decision is needed for a token. A decision request carries the direction, the endpoint number and whether the token belongs to the status stage. The decision appears one clock later as a 2-bit code.

Each flag clears in its own way. A setup token clears only the endpoint-0 flags. The acknowledge flag is the most short-lived: it clears on a setup token, on a sent status ACK, and whenever any stall flag is set.

Top module: `usb_ep_stall_hs`

## Requirements
- R1: After reset every bit of the control word reads 0. Bit 7 always reads 0, even after a write of 1 to it. The bit positions are: 6 = status acknowledge, 5 = status stall, 4 = EP3-IN stall, 3 = EP2-IN stall, 2 = EP1-OUT stall, 1 = EP0-OUT stall, 0 = EP0-IN stall.
- R2: The word is written and read only when the 5-bit register select equals 8. Any other select reads 0 and a write there leaves the word unchanged.
- R3: A token whose direction and endpoint match a set stall bit gets STALL (code 11), whatever the status-stage flags and the status indication are. Direction is 1 for IN and 0 for OUT.
- R4: A status-stage token to endpoint 0 with both status flags clear and no matching stall bit gets NAK (code 10).
- R5: A status-stage token to endpoint 0 gets STALL when the status-stall flag is set. When that flag is clear and the acknowledge flag is set, it gets ACK (code 01).
- R6: A status-ACK-sent event clears the acknowledge flag.
- R7: A setup event clears bits 6, 5, 1 and 0. Bits 4 to 2 keep their value.
- R8: The acknowledge flag is clear after any cycle that sets a stall bit. This includes a single write that sets the acknowledge flag together with any stall bit.
- R9: When a CPU write and a hardware clear event fall in the same cycle, the hardware clear wins for the bits it covers. The write still takes effect on the other bits.
- R10: The handshake code appears with a valid strobe exactly one cycle after a request strobe, and reads 00 when there is no request. A request outside the status stage that matches no set stall bit gets 00 (no override). A request to a direction and endpoint pair that is not covered also gets 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 5 | Register select |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational from the select |
| evt_setup | input | 1 | Setup token arrived (one-cycle pulse) |
| evt_stat_ack | input | 1 | Status-stage ACK was sent (one-cycle pulse) |
| tok_req | input | 1 | Handshake decision request |
| tok_in | input | 1 | Token direction, 1 = IN |
| tok_ep | input | 2 | Token endpoint number |
| tok_status | input | 1 | Token is in the control status stage |
| hs_valid | output | 1 | Decision valid, one cycle after tok_req |
| hs_code | output | 2 | 00 none, 01 ACK, 10 NAK, 11 STALL |

## Verification
A bit left set when it should have cleared shows in two ways. It appears directly on the read port in the very next cycle. It also changes the code returned to the next decision request: a stale stall gives 11 instead of 00 or 10, and a stale acknowledge gives 01 instead of 10. The bench writes every legal value of the low seven bits. For each value it asks for a decision on every direction, endpoint and stage combination, so a wrong bit-to-endpoint mapping or a wrong priority shows within one request. Separate sequences fire each clear event alone and together with a write, then read the word back at once.

// File: rtl/usb_ep_stall_pkg.sv
package usb_ep_stall_pkg;

  localparam int CW_W       = 7;   // stored bits of the control word
  localparam int B_EP0_IN   = 0;
  localparam int B_EP0_OUT  = 1;
  localparam int B_EP1_OUT  = 2;
  localparam int B_EP2_IN   = 3;
  localparam int B_EP3_IN   = 4;
  localparam int B_ST_STALL = 5;
  localparam int B_ST_ACK   = 6;

  localparam logic [CW_W-1:0] SETUP_CLR_MASK =
    (CW_W'(1) << B_ST_ACK) | (CW_W'(1) << B_ST_STALL) |
    (CW_W'(1) << B_EP0_OUT) | (CW_W'(1) << B_EP0_IN);

  localparam logic [CW_W-1:0] STALL_MASK = CW_W'(7'h3F);

  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_e;

  // Stall bit that governs a direction/endpoint pair, if any.
  function automatic logic ep_stall_hit(input logic [CW_W-1:0] cw,
                                        input logic dir_in,
                                        input logic [1:0] ep);
    logic hit;
    hit = 1'b0;
    if (dir_in) begin
      case (ep)
        2'd0: hit = cw[B_EP0_IN];
        2'd2: hit = cw[B_EP2_IN];
        2'd3: hit = cw[B_EP3_IN];
        default: hit = 1'b0;
      endcase
    end else begin
      case (ep)
        2'd0: hit = cw[B_EP0_OUT];
        2'd1: hit = cw[B_EP1_OUT];
        default: hit = 1'b0;
      endcase
    end
    return hit;
  endfunction

  // Full handshake choice for one token.
  function automatic hs_e hs_pick(input logic [CW_W-1:0] cw,
                                  input logic dir_in,
                                  input logic [1:0] ep,
                                  input logic status);
    hs_e r;
    if (ep_stall_hit(cw, dir_in, ep))             r = HS_STALL;
    else if (status && ep == 2'd0) begin
      if (cw[B_ST_STALL])                         r = HS_STALL;
      else if (cw[B_ST_ACK])                      r = HS_ACK;
      else                                        r = HS_NAK;
    end else                                      r = HS_NONE;
    return r;
  endfunction

endpackage

// File: rtl/usb_ep_stall_cpu_port.sv
module usb_ep_stall_cpu_port
  import usb_ep_stall_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 8,
  parameter int REG_ADDR = 8
) (
  input  logic [ADDR_W-1:0] cpu_sel,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [CW_W-1:0]   cw_q,
  output logic              wr_hit,
  output logic [CW_W-1:0]   wr_val,
  output logic [DATA_W-1:0] cpu_rdata
);
  localparam logic [ADDR_W-1:0] SEL_MATCH = ADDR_W'(REG_ADDR);
  localparam int PAD_W = DATA_W - CW_W;

  logic sel_hit;
  assign sel_hit  = (cpu_sel == SEL_MATCH);
  assign wr_hit   = sel_hit & cpu_wr;
  assign wr_val   = cpu_wdata[CW_W-1:0];
  assign cpu_rdata = sel_hit ? {{PAD_W{1'b0}}, cw_q} : '0;
endmodule

// File: rtl/usb_ep_stall_ctrl_reg.sv
module usb_ep_stall_ctrl_reg
  import usb_ep_stall_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_hit,
  input  logic [CW_W-1:0] wr_val,
  input  logic            evt_setup,
  input  logic            evt_stat_ack,
  output logic [CW_W-1:0] cw_q,
  output logic            ack_kill,
  output logic [5:0]      stall_rise
);
  logic [CW_W-1:0] cw_d;
  logic [CW_W-1:0] after_wr;
  logic            wr_pair;

  always_comb begin
    after_wr   = wr_hit ? wr_val : cw_q;
    stall_rise = after_wr[5:0] & ~cw_q[5:0];
    wr_pair    = wr_hit & wr_val[B_ST_ACK] & (|(wr_val & STALL_MASK));
    ack_kill   = evt_setup | evt_stat_ack | (|stall_rise) | wr_pair;
    cw_d       = after_wr;
    if (evt_setup) cw_d = cw_d & ~SETUP_CLR_MASK;
    if (ack_kill)  cw_d[B_ST_ACK] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cw_q <= '0;
    else        cw_q <= cw_d;
  end
endmodule

// File: rtl/usb_ep_stall_decide.sv
module usb_ep_stall_decide
  import usb_ep_stall_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW_W-1:0] cw_q,
  input  logic            tok_req,
  input  logic            tok_in,
  input  logic [1:0]      tok_ep,
  input  logic            tok_status,
  output logic            stall_hit,
  output logic            hs_valid,
  output logic [1:0]      hs_code
);
  hs_e pick;
  assign stall_hit = ep_stall_hit(cw_q, tok_in, tok_ep);
  assign pick      = hs_pick(cw_q, tok_in, tok_ep, tok_status);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_valid <= 1'b0;
      hs_code  <= HS_NONE;
    end else begin
      hs_valid <= tok_req;
      hs_code  <= tok_req ? pick : HS_NONE;
    end
  end
endmodule

// File: rtl/usb_ep_stall_hs.sv
module usb_ep_stall_hs
  import usb_ep_stall_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 8,
  parameter int REG_ADDR = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_sel,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              evt_setup,
  input  logic              evt_stat_ack,
  input  logic              tok_req,
  input  logic              tok_in,
  input  logic [1:0]        tok_ep,
  input  logic              tok_status,
  output logic              hs_valid,
  output logic [1:0]        hs_code
);
  logic            wr_hit;
  logic [CW_W-1:0] wr_val;
  logic [CW_W-1:0] cw_q;
  logic            ack_kill;
  logic [5:0]      stall_rise;
  logic            stall_hit;

  usb_ep_stall_cpu_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)
  ) u_port (
    .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cw_q(cw_q), .wr_hit(wr_hit), .wr_val(wr_val), .cpu_rdata(cpu_rdata)
  );

  usb_ep_stall_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_val(wr_val),
    .evt_setup(evt_setup), .evt_stat_ack(evt_stat_ack),
    .cw_q(cw_q), .ack_kill(ack_kill), .stall_rise(stall_rise)
  );

  usb_ep_stall_decide u_dec (
    .clk(clk), .rst_n(rst_n), .cw_q(cw_q),
    .tok_req(tok_req), .tok_in(tok_in), .tok_ep(tok_ep), .tok_status(tok_status),
    .stall_hit(stall_hit), .hs_valid(hs_valid), .hs_code(hs_code)
  );
endmodule

// File: rtl/usb_ep_stall_hs_chk.sv
module usb_ep_stall_hs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] cw_q,
  input logic [7:0] cpu_rdata,
  input logic       wr_hit,
  input logic       evt_setup,
  input logic       evt_stat_ack,
  input logic       tok_req,
  input logic       stall_hit,
  input logic       hs_valid,
  input logic [1:0] hs_code
);
  assert_bit7_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata[7] == 1'b0);

  assert_stall_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_req && stall_hit) |=> (hs_code == 2'b11));

  assert_statack_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stat_ack |=> !cw_q[6]);

  assert_setup_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_setup |=> (cw_q[6] == 1'b0 && cw_q[5] == 1'b0 && cw_q[1:0] == 2'b00));

  assert_setup_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_setup && !wr_hit) |=> $stable(cw_q[4:2]));

  assert_ack_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cw_q[6] |-> (cw_q[5:0] == 6'd0));

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tok_req |=> hs_valid);

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_req |=> (!hs_valid && hs_code == 2'b00));
endmodule

bind usb_ep_stall_hs usb_ep_stall_hs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cw_q(cw_q), .cpu_rdata(cpu_rdata),
  .wr_hit(wr_hit), .evt_setup(evt_setup), .evt_stat_ack(evt_stat_ack),
  .tok_req(tok_req), .stall_hit(stall_hit),
  .hs_valid(hs_valid), .hs_code(hs_code)
);

// File: tb/sim_usb_ep_stall_hs.sv
module sim_usb_ep_stall_hs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] cpu_sel = '0;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       evt_setup = 1'b0, evt_stat_ack = 1'b0;
  logic       tok_req = 1'b0, tok_in = 1'b0, tok_status = 1'b0;
  logic [1:0] tok_ep = '0;
  logic       hs_valid;
  logic [1:0] hs_code;

  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  usb_ep_stall_hs u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench model: value kept after a plain write.
  function automatic logic [7:0] after_write(input logic [7:0] w);
    logic [7:0] v;
    v = w % 8'd128;
    if (v >= 8'd64 && (v % 8'd64) != 0) v = v - 8'd64;
    return v;
  endfunction

  // Bench model: handshake expected for a token.
  function automatic int expect_hs(input logic [7:0] r, input logic din,
                                   input int ep, input logic st);
    int idx;
    idx = -1;
    if (din)  idx = (ep == 0) ? 0 : (ep == 2) ? 3 : (ep == 3) ? 4 : -1;
    else      idx = (ep == 0) ? 1 : (ep == 1) ? 2 : -1;
    if (idx >= 0 && ((r >> idx) & 1) == 1) return 3;
    if (st && ep == 0) begin
      if (((r >> 5) & 1) == 1) return 3;
      if (((r >> 6) & 1) == 1) return 1;
      return 2;
    end
    return 0;
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cpu_sel = 5'(a); cpu_wdata = 8'(d); cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_sel = 5'd8;
  endtask

  task automatic rd_chk(input string req, input int exp);
    cpu_sel = 5'd8; #0.5;
    chk(req, int'(cpu_rdata), exp);
  endtask

  task automatic token(input string req, input logic din, input int ep,
                       input logic st, input int exp);
    @(negedge clk);
    tok_req = 1'b1; tok_in = din; tok_ep = 2'(ep); tok_status = st;
    @(negedge clk);
    tok_req = 1'b0;
    chk({req, " valid"}, int'(hs_valid), 1);
    chk(req, int'(hs_code), exp);
  endtask

  task automatic pulse(input logic s, input logic a);
    @(negedge clk);
    evt_setup = s; evt_stat_ack = a;
    @(negedge clk);
    evt_setup = 1'b0; evt_stat_ack = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cpu_sel = 5'd8;
    @(negedge clk);
    rd_chk("R1 reset", 0);
    chk("R10 reset valid", int'(hs_valid), 0);
    chk("R10 idle code", int'(hs_code), 0);

    wr(8, 8'hFF);
    rd_chk("R1 bit7 reads 0", 8'h3F);
    wr(8, 0);
    rd_chk("R1 cleared", 0);

    wr(5'h09, 8'h1C);
    rd_chk("R2 other select no write", 0);
    cpu_sel = 5'h09; #0.5;
    chk("R2 other select reads 0", int'(cpu_rdata), 0);
    cpu_sel = 5'd8;
    wr(8, 8'h40);
    cpu_sel = 5'h00; #0.5;
    chk("R2 select 0 reads 0", int'(cpu_rdata), 0);
    cpu_sel = 5'd8;
    rd_chk("R2 word at 8", 8'h40);

    // Sweep all stored values and all token shapes (R3 R4 R5 R8 R10)
    for (int v = 0; v < 128; v++) begin
      logic [7:0] m;
      m = after_write(8'(v));
      wr(8, v);
      rd_chk("R8 write model", int'(m));
      for (int t = 0; t < 16; t++) begin
        logic din, st;
        int ep, e;
        din = t[0]; st = t[1]; ep = t / 4;
        e = expect_hs(m, din, ep, st);
        token((e == 3) ? "R3/R5 stall" : (e == 2) ? "R4 nak" :
              (e == 1) ? "R5 ack" : "R10 none", din, ep, st, e);
      end
    end

    // R6
    wr(8, 8'h40);
    pulse(1'b0, 1'b1);
    rd_chk("R6 ack cleared by sent ACK", 0);
    token("R4 nak after R6 clear", 1'b1, 0, 1'b1, 2);

    // R7
    wr(8, 8'h3F);
    pulse(1'b1, 1'b0);
    rd_chk("R7 setup clears ep0 and status stall", 8'h1C);
    wr(8, 8'h40);
    pulse(1'b1, 1'b0);
    rd_chk("R7 setup clears ack", 0);

    // R8: setting a stall after ack was set
    wr(8, 8'h40);
    wr(8, 8'h41);
    rd_chk("R8 ack with stall", 8'h01);

    // R9: write and hardware clear in the same cycle
    @(negedge clk);
    cpu_wr = 1'b1; cpu_wdata = 8'h3F; evt_setup = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0; evt_setup = 1'b0;
    rd_chk("R9 setup beats write", 8'h1C);
    wr(8, 0);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_wdata = 8'h40; evt_stat_ack = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0; evt_stat_ack = 1'b0;
    rd_chk("R9 status ACK beats write", 0);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_wdata = 8'h40; evt_setup = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0; evt_setup = 1'b0;
    rd_chk("R9 setup beats ack write", 0);

    @(negedge clk);
    chk("R10 no request no valid", int'(hs_valid), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule